// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block turns a set of pending interrupt sources into one priority level and decides whether that level should interrupt the processor. Two request words feed it: a software request word, whose valid bits map to the low levels 1 to 15, and an external request word, whose valid bits map directly to levels 20 to 30. Because every valid external level is numerically above every software level, any pending external line outranks all software requests. The winning level is compared against a 5-bit current-level threshold. A trap is requested only when the level is nonzero and strictly above that threshold.

Evaluation is not continuous. The surrounding core pulses an arm strobe, for example after each return from an exception. The block then evaluates once, in the following cycle, and disarms itself. When that evaluation finds a level above the threshold, the block raises a one-cycle trap request. In the same cycle it latches two values: a summary word holding every valid pending source bit, and the winning level as an ID. Both values hold until the next trap is taken. Steering execution to the handler belongs to the consumer of the trap request.

Top module: `ipl_evaluator`

## Requirements
- R1: Software request bits 4 through 18 are valid; a set bit at position i has level i-3 (levels 1..15). All other software bits are ignored: they reach neither the level nor the summary.
- R2: External request bits 20 through 30 are valid; a set bit at position i has level i. All other external bits are ignored: they reach neither the level nor the summary.
- R3: The highest pending level wins. Any valid pending external bit outranks every software bit.
- R4: A trap is requested only when the winning level is nonzero and strictly greater than the threshold, compared as unsigned 5-bit values. An equal level does not trap.
- R5: The arm strobe is sampled at a clock edge. The evaluation uses the inputs present during the next cycle. trap_req goes high for exactly one cycle after that cycle's closing edge.
- R6: Each arm strobe gives exactly one evaluation. Without an arm strobe, no trap is raised, whatever the inputs are. Reset leaves the block disarmed.
- R7: When a trap is taken, pend_summary takes the OR of all valid pending software and external bits, each at its own bit position, and win_id takes the winning level.
- R8: pend_summary and win_id reset to zero and keep their values in every cycle in which no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 32 | Software request word (valid bits 4..18) |
| ext_req | input | 32 | External interrupt lines (valid bits 20..30) |
| ipl_thresh | input | 5 | Current interrupt level threshold |
| eval_arm | input | 1 | One-shot strobe that arms a single evaluation |
| trap_req | output | 1 | One-cycle interrupt trap request |
| pend_summary | output | 32 | Latched summary of pending sources at the last trap |
| win_id | output | 5 | Latched winning level at the last trap |

## Verification
A wrong internal state in this block shows at the ports one cycle after the evaluation cycle. A stuck arm flag shows as a trap with no strobe, or as a second trap pulse. A wrong encoder level or mask shows as a wrong win_id, or as an extra or missing pend_summary bit, on that same trap. A compare error near the threshold shows as a trap at an equal level, or as no trap one level above it. Between traps, any corruption of the capture registers shows as a change in pend_summary or win_id with trap_req low, so the bench checks the held values after every evaluation that does not trap.

// File: rtl/ipl_pkg.sv
// Shared widths and source layout for the interrupt priority level evaluator.
// Assumes all levels fit in LVL_W bits and that external levels sit above
// every software level.
package ipl_pkg;
    localparam int REQ_W  = 32;
    localparam int LVL_W  = 5;
    localparam int SW_LO  = 4;
    localparam int SW_HI  = 18;
    localparam int SW_OFS = 3;
    localparam int EXT_LO = 20;
    localparam int EXT_HI = 30;
endpackage

// File: rtl/ipl_range_encoder.sv
// Range-limited priority encoder.
// Passes only bits LO..HI of the request word and reports the level of the
// highest set bit, computed as its position minus OFS.
// Assumes LO <= HI < W and HI - OFS < 2**LVL_W.
module ipl_range_encoder #(
    parameter int W     = 32,
    parameter int LVL_W = 5,
    parameter int LO    = 4,
    parameter int HI    = 18,
    parameter int OFS   = 3
) (
    input  logic [W-1:0]     req,
    output logic [W-1:0]     pend,
    output logic             any,
    output logic [LVL_W-1:0] lvl
);
    // Keep only the bit positions that belong to this source range.
    for (genvar g = 0; g < W; g++) begin : g_mask
        if (g >= LO && g <= HI) begin : g_in
            assign pend[g] = req[g];
        end else begin : g_out
            assign pend[g] = 1'b0;
        end
    end

    // An ascending scan lets the highest set position win.
    always_comb begin
        lvl = '0;
        for (int i = LO; i <= HI; i++) begin
            if (pend[i]) lvl = LVL_W'(i - OFS);
        end
    end

    // Flags whether any valid bit in the range is pending.
    assign any = |pend;
endmodule

// File: rtl/ipl_capture.sv
// Threshold compare and capture stage.
// On an evaluation cycle whose level is nonzero and above the threshold, this
// stage pulses trap for one cycle and latches the summary and the level.
// Assumes eval_en is high for at most the evaluation cycles.
module ipl_capture #(
    parameter int W     = 32,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_en,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic [LVL_W-1:0] thresh,
    input  logic [W-1:0]     pend_all,
    output logic             trap,
    output logic [W-1:0]     summary,
    output logic [LVL_W-1:0] int_id
);
    logic take;

    // Decides whether this cycle's evaluation produces a trap.
    assign take = eval_en && (win_lvl != '0) && (win_lvl > thresh);

    // Registers the trap pulse and captures summary and ID on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap    <= 1'b0;
            summary <= '0;
            int_id  <= '0;
        end else begin
            trap <= take;
            if (take) begin
                summary <= pend_all;
                int_id  <= win_lvl;
            end
        end
    end

    AST_TRAP_ABOVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (int_id != '0 && int_id > $past(thresh))); // R4
    AST_TRAP_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(eval_en)); // R6
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> ($stable(summary) && $stable(int_id))); // R8
endmodule

// File: rtl/ipl_evaluator.sv
// Interrupt priority level evaluator top.
// Merges the software and external request words into one level. An external
// source always outranks software. The level is evaluated once per arm strobe
// against the current threshold.
// Assumes the request inputs are synchronous to clk.
module ipl_evaluator
    import ipl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] sw_req,
    input  logic [REQ_W-1:0] ext_req,
    input  logic [LVL_W-1:0] ipl_thresh,
    input  logic             eval_arm,
    output logic             trap_req,
    output logic [REQ_W-1:0] pend_summary,
    output logic [LVL_W-1:0] win_id
);
    localparam int SW_LVL_MIN = SW_LO - SW_OFS;
    localparam int SW_LVL_MAX = SW_HI - SW_OFS;

    logic [REQ_W-1:0] sw_pend, ext_pend;
    logic             sw_any, ext_any;
    logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
    logic             armed_q;

    ipl_range_encoder #(.W(REQ_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI), .OFS(SW_OFS))
        u_sw_enc (.req(sw_req), .pend(sw_pend), .any(sw_any), .lvl(sw_lvl));

    ipl_range_encoder #(.W(REQ_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI), .OFS(0))
        u_ext_enc (.req(ext_req), .pend(ext_pend), .any(ext_any), .lvl(ext_lvl));

    // Any pending external source overrides the software level.
    assign win_lvl = ext_any ? ext_lvl : sw_lvl;

    // One-shot arm: set by the strobe, consumed by the following evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= eval_arm;
    end

    ipl_capture #(.W(REQ_W), .LVL_W(LVL_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .eval_en(armed_q), .win_lvl(win_lvl),
        .thresh(ipl_thresh), .pend_all(sw_pend | ext_pend),
        .trap(trap_req), .summary(pend_summary), .int_id(win_id)
    );

    AST_SW_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_any |-> (int'(sw_lvl) >= SW_LVL_MIN && int'(sw_lvl) <= SW_LVL_MAX)); // R1
    AST_EXT_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_any |-> (int'(ext_lvl) >= EXT_LO && int'(ext_lvl) <= EXT_HI)); // R2
    AST_EXT_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && $past(ext_any)) |-> (win_id == $past(ext_lvl))); // R3
    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !$past(eval_arm)) |=> !trap_req); // R5
endmodule

// File: tb/sim_ipl_evaluator.sv
`timescale 1ns/1ps
module sim_ipl_evaluator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sw_req = '0, ext_req = '0;
    logic [4:0]  ipl_thresh = '0;
    logic        eval_arm = 1'b0;
    logic        trap_req;
    logic [31:0] pend_summary;
    logic [4:0]  win_id;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { string tag; bit trap; logic [31:0] sum; logic [4:0] id; } exp_t;
    exp_t sb[$];
    event sample_ev;
    logic [31:0] m_sum = '0;
    logic [4:0]  m_id = '0;

    always #2.5 clk = ~clk;

    ipl_evaluator u0 (.clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_req(ext_req),
        .ipl_thresh(ipl_thresh), .eval_arm(eval_arm), .trap_req(trap_req),
        .pend_summary(pend_summary), .win_id(win_id));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: written from the requirement text.
    task automatic model(input logic [31:0] s, input logic [31:0] e, input logic [4:0] t,
                         output bit tr, output logic [31:0] sum, output logic [4:0] lv);
        int best = 0;
        bit ext_seen = 0;
        sum = '0;
        for (int i = 4; i <= 18; i++) if (s[i]) begin sum[i] = 1'b1; best = i - 3; end
        for (int i = 20; i <= 30; i++) if (e[i]) begin sum[i] = 1'b1; best = i; ext_seen = 1; end
        lv = 5'(best);
        tr = (best != 0) && (best > int'(t));
    endtask

    // Driver: applies one armed evaluation and pushes the expected result.
    task automatic evaluate(string tag, logic [31:0] s, logic [31:0] e, logic [4:0] t);
        exp_t x;
        bit tr; logic [31:0] sum; logic [4:0] lv;
        model(s, e, t, tr, sum, lv);
        if (tr) begin m_sum = sum; m_id = lv; end
        x.tag = tag; x.trap = tr; x.sum = m_sum; x.id = m_id;
        sb.push_back(x);
        @(negedge clk);
        sw_req = s; ext_req = e; ipl_thresh = t; eval_arm = 1'b1;
        @(negedge clk);
        eval_arm = 1'b0;
        @(negedge clk);
        -> sample_ev;
        #0.5;
        @(negedge clk);
        check({tag, " R5 pulse drops"}, 32'(trap_req), 32'd0);
    endtask

    // Monitor: pops the expected items and compares them with the outputs.
    initial forever begin
        exp_t x;
        @(sample_ev);
        x = sb.pop_front();
        check({x.tag, " trap"}, 32'(trap_req), 32'(x.trap));
        check({x.tag, " summary"}, pend_summary, x.sum);
        check({x.tag, " id"}, 32'(win_id), 32'(x.id));
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R8 reset trap", 32'(trap_req), 32'd0);
        check("R8 reset summary", pend_summary, 32'd0);
        check("R8 reset id", 32'(win_id), 32'd0);
        // Pending sources right out of reset, no strobe: disarmed (R6).
        sw_req = 32'h0004_0000; ext_req = 32'h4000_0000;
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check("R6 no arm after reset", 32'(trap_req), 32'd0);
        end
        check("R6 summary untouched", pend_summary, 32'd0);
        evaluate("R1 lowest sw bit", 32'h0000_0010, 32'h0, 5'd0);
        evaluate("R1 sw highest wins", 32'h0004_0400, 32'h0, 5'd0);
        evaluate("R1 invalid sw bits", 32'h8008_0008, 32'h0, 5'd0);
        evaluate("R2 invalid ext bits", 32'h0, 32'h8008_0000, 5'd0);
        evaluate("R3 ext beats sw", 32'h0004_0010, 32'h0010_0000, 5'd0);
        evaluate("R3 highest ext", 32'h0000_0100, 32'h0210_0000, 5'd3);
        evaluate("R2 top ext level", 32'h0, 32'h4000_0000, 5'd29);
        evaluate("R4 equal level no trap", 32'h0, 32'h0200_0000, 5'd25);
        evaluate("R4 below threshold", 32'h0, 32'h0200_0000, 5'd26);
        evaluate("R4 one above threshold", 32'h0, 32'h0200_0000, 5'd24);
        evaluate("R4 max threshold", 32'h0007_fff0, 32'h7ff0_0000, 5'd31);
        evaluate("R4 zero level", 32'h0, 32'h0, 5'd0);
        evaluate("R7 all valid sources", 32'hffff_ffff, 32'hffff_ffff, 5'd0);
        evaluate("R4 sw level at threshold", 32'h0000_0020, 32'h0, 5'd2);
        evaluate("R7 sw level above threshold", 32'h0000_0060, 32'h0, 5'd2);
        // One-shot: new high-level inputs without a strobe stay silent (R6).
        @(negedge clk);
        sw_req = 32'h0004_0000; ext_req = 32'h4000_0000; ipl_thresh = 5'd0;
        repeat (6) begin
            @(negedge clk);
            check("R6 one evaluation per arm", 32'(trap_req), 32'd0);
        end
        check("R8 summary held", pend_summary, m_sum);
        check("R8 id held", 32'(win_id), 32'(m_id));
        // Back-to-back strobes give two evaluations (R6).
        @(negedge clk);
        eval_arm = 1'b1;
        @(negedge clk);
        @(negedge clk);
        eval_arm = 1'b0;
        check("R6 first of two", 32'(trap_req), 32'd1);
        @(negedge clk);
        check("R6 second of two", 32'(trap_req), 32'd1);
        check("R7 id after pair", 32'(win_id), 32'd30);
        @(negedge clk);
        check("R5 drops after pair", 32'(trap_req), 32'd0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule